// File: doc/BRIEF.md
# Processor clock-stop and restart controller

This block sits between a free-running system clock and the clock pin of a static processor. It watches the processor bus for one particular access: a write, in supervisor data space, to a configurable power-down address. That access arms a short count of bus cycles. When the bus cycle that fetches the halt instruction's immediate operand has completed, the block closes its clock gate. The processor then keeps its internal state with no clock at all.

The gate stays closed until an active-high restart request arrives. The restart request is normally raised by outside logic after the system clock has settled again. The gate opens on the next falling edge of the system clock, so the first processor clock pulse is a full high phase. While the clock is stopped, the block compares the inverted interrupt-priority lines against a programmed wake level and flags a match. It can also hold a bus-request line asserted, and it always drops that line before the processor runs again.

All bus inputs are sampled on the falling edge of the system clock. One static select input chooses a 16-bit or an 8-bit data bus, and with it the depth of the count.

Top module: `cstop_ctrl`

## Requirements
- R1: A bus cycle arms the sequence only if all of the following hold while `bus_as_n` is sampled low: `bus_addr` equals `pd_addr` on all 24 bits, `bus_rw` is 0 (write), and `bus_fc` is 3'b101. A cycle that differs in any one of these has no effect.
- R2: Counting starts with the arming cycle itself. A cycle is counted when its strobe completes, which is a falling-edge sample of `bus_as_n` high directly after a sample of it low.
- R3: With `narrow_bus` = 0 (16-bit bus), the gate closes at the second counted completion and not before.
- R4: With `narrow_bus` = 1 (8-bit bus), the gate closes at the third counted completion and not before.
- R5: The gate closes on the same system-clock falling edge that samples the qualifying completion. From then on `stopped` is 1 and `cpu_clk` stays low for as long as the block is stopped.
- R6: While stopped, `restart` = 1 sampled at a falling edge reopens the gate at that edge and returns `stopped` to 0, and `cpu_clk` is high in the next system-clock high phase. A `restart` seen while not stopped has no effect.
- R7: `rst_n` low (asynchronous, active low) abandons any partial count, leaves the block idle with the gate open, and ends a stop.
- R8: Every high pulse of `cpu_clk` starts on a rising edge of `sys_clk` and lasts exactly one high phase of `sys_clk`.
- R9: While a sequence is armed or stopped, `bus_req` follows `hold_req` as sampled at falling edges. `bus_req` is 0 from the falling edge that takes the restart onward, so it is low at the first `cpu_clk` rising edge after a stop.
- R10: `narrow_bus` is sampled only while the block is idle. A change in the middle of a sequence does not change that sequence's count depth.
- R11: `wake_hit` is 1 exactly when `stopped` is 1 and the value of `~ipl_n` is at least `wake_level`, compared as unsigned 3-bit numbers. It is 0 whenever the block is not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Processor address bus |
| bus_rw | input | 1 | Read/write line, 1 = read, 0 = write |
| bus_fc | input | 3 | Processor function code |
| bus_as_n | input | 1 | Active-low address strobe |
| pd_addr | input | 24 | Configured power-down address |
| narrow_bus | input | 1 | 1 = 8-bit data bus, 0 = 16-bit |
| restart | input | 1 | Active-high request to resume the clock |
| hold_req | input | 1 | Request to keep the bus-request line asserted during the sequence |
| ipl_n | input | 3 | Active-low interrupt-priority lines |
| wake_level | input | 3 | Programmed wake priority threshold |
| cpu_clk | output | 1 | Gated processor clock |
| bus_req | output | 1 | Bus-request output |
| stopped | output | 1 | 1 while the processor clock is held off |
| wake_hit | output | 1 | Interrupt level at or above the wake level while stopped |

## Verification
The bench sends near-miss cycles, each with only one of address, direction or function code wrong. A decoder that checks too few terms would stop the clock on one of them. It counts completions one at a time in both bus widths, so an off-by-one chain would stop early or late. It flips the width select in the middle of a sequence, which catches a design that samples the width outside the idle state.

Every gated high pulse is timed, and no gated pulse may appear while the block is stopped. The bus-request line is checked at the first rising edge after a restart, and the wake flag is checked with the level one below, equal to and above the threshold. Resets are placed in the middle of a count and during a stop, to catch a count that survives reset or a gate that stays closed.

// File: rtl/cstop_pkg.sv
package cstop_pkg;

  localparam int unsigned IPL_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_STOP  = 2'd2
  } seq_state_t;

  // Number of strobe completions, counting the arming write, before gating.
  function automatic int unsigned gate_after(logic narrow,
                                             int unsigned wide_n,
                                             int unsigned narrow_n);
    return narrow ? narrow_n : wide_n;
  endfunction

  // Active-low priority lines converted to a level and compared to a threshold.
  function automatic logic meets_level(logic [IPL_W-1:0] lines_n,
                                       logic [IPL_W-1:0] thresh);
    logic [IPL_W-1:0] lvl;
    lvl = ~lines_n;
    return lvl >= thresh;
  endfunction

endpackage

// File: rtl/cstop_bus_watch.sv
module cstop_bus_watch #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned FC_W    = 3,
  parameter logic [FC_W-1:0] SUPV_FC = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic [FC_W-1:0]   fc,
  input  logic              as_n,
  input  logic [ADDR_W-1:0] pd_addr,
  output logic              cycle_match,
  output logic              cycle_done
);

  logic as_low_q;
  logic addr_eq;
  logic is_write;
  logic fc_ok;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) as_low_q <= 1'b0;
    else        as_low_q <= ~as_n;
  end

  assign addr_eq     = (addr == pd_addr);
  assign is_write    = ~rw;
  assign fc_ok       = (fc == SUPV_FC);
  assign cycle_match = ~as_n & addr_eq & is_write & fc_ok;
  assign cycle_done  = as_low_q & as_n;

endmodule

// File: rtl/cstop_seq.sv
module cstop_seq
  import cstop_pkg::*;
#(
  parameter int unsigned WIDE_N   = 2,
  parameter int unsigned NARROW_N = 3,
  parameter int unsigned CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_match,
  input  logic             cycle_done,
  input  logic             narrow_bus,
  input  logic             restart,
  input  logic             hold_req,
  output logic             stop_fire,
  output logic             restart_fire,
  output logic             stopped,
  output logic             busy,
  output logic             width_sel,
  output logic             bus_req,
  output logic [CNT_W-1:0] cnt
);

  seq_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_next;

  assign target   = CNT_W'(gate_after(width_sel, WIDE_N, NARROW_N));
  assign cnt_next = cnt + 1'b1;

  assign stop_fire    = (state_q == ST_COUNT) && cycle_done && (cnt_next == target);
  assign restart_fire = (state_q == ST_STOP) && restart;
  assign stopped      = (state_q == ST_STOP);
  assign busy         = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (cycle_match) state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (stop_fire) begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end else if (cycle_done) begin
          cnt_d = cnt_next;
        end
      end
      ST_STOP: begin
        if (restart_fire) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt       <= '0;
      width_sel <= 1'b0;
      bus_req   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt     <= cnt_d;
      if (state_q == ST_IDLE) width_sel <= narrow_bus;
      if (restart_fire)           bus_req <= 1'b0;
      else if (state_q != ST_IDLE) bus_req <= hold_req;
      else                         bus_req <= 1'b0;
    end
  end

endmodule

// File: rtl/cstop_gate.sv
module cstop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_fire,
  input  logic restart_fire,
  output logic run_en,
  output logic gclk
);

  // Enable moves only just after a falling edge, while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)            run_en <= 1'b1;
    else if (stop_fire)    run_en <= 1'b0;
    else if (restart_fire) run_en <= 1'b1;
  end

  assign gclk = clk & run_en;

endmodule

// File: rtl/cstop_wake.sv
module cstop_wake
  import cstop_pkg::*;
(
  input  logic             stopped,
  input  logic [IPL_W-1:0] ipl_n,
  input  logic [IPL_W-1:0] wake_level,
  output logic             wake_hit
);

  assign wake_hit = stopped & meets_level(ipl_n, wake_level);

endmodule

// File: rtl/cstop_ctrl.sv
module cstop_ctrl
  import cstop_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned FC_W     = 3,
  parameter logic [FC_W-1:0] SUPV_FC = 3'b101,
  parameter int unsigned WIDE_N   = 2,
  parameter int unsigned NARROW_N = 3
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rw,
  input  logic [FC_W-1:0]   bus_fc,
  input  logic              bus_as_n,
  input  logic [ADDR_W-1:0] pd_addr,
  input  logic              narrow_bus,
  input  logic              restart,
  input  logic              hold_req,
  input  logic [IPL_W-1:0]  ipl_n,
  input  logic [IPL_W-1:0]  wake_level,
  output logic              cpu_clk,
  output logic              bus_req,
  output logic              stopped,
  output logic              wake_hit
);

  localparam int unsigned MAX_N = (WIDE_N > NARROW_N) ? WIDE_N : NARROW_N;
  localparam int unsigned CNT_W = $clog2(MAX_N + 1);

  logic             cycle_match;
  logic             cycle_done;
  logic             stop_fire;
  logic             restart_fire;
  logic             busy;
  logic             width_sel;
  logic             run_en;
  logic [CNT_W-1:0] cnt;

  cstop_bus_watch #(
    .ADDR_W (ADDR_W),
    .FC_W   (FC_W),
    .SUPV_FC(SUPV_FC)
  ) u_watch (
    .clk        (sys_clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .rw         (bus_rw),
    .fc         (bus_fc),
    .as_n       (bus_as_n),
    .pd_addr    (pd_addr),
    .cycle_match(cycle_match),
    .cycle_done (cycle_done)
  );

  cstop_seq #(
    .WIDE_N  (WIDE_N),
    .NARROW_N(NARROW_N),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk         (sys_clk),
    .rst_n       (rst_n),
    .cycle_match (cycle_match),
    .cycle_done  (cycle_done),
    .narrow_bus  (narrow_bus),
    .restart     (restart),
    .hold_req    (hold_req),
    .stop_fire   (stop_fire),
    .restart_fire(restart_fire),
    .stopped     (stopped),
    .busy        (busy),
    .width_sel   (width_sel),
    .bus_req     (bus_req),
    .cnt         (cnt)
  );

  cstop_gate u_gate (
    .clk         (sys_clk),
    .rst_n       (rst_n),
    .stop_fire   (stop_fire),
    .restart_fire(restart_fire),
    .run_en      (run_en),
    .gclk        (cpu_clk)
  );

  cstop_wake u_wake (
    .stopped   (stopped),
    .ipl_n     (ipl_n),
    .wake_level(wake_level),
    .wake_hit  (wake_hit)
  );

endmodule

// File: rtl/cstop_ctrl_chk.sv
module cstop_ctrl_chk #(
  parameter int unsigned CNT_W = 2,
  parameter int unsigned LIMIT = 3
) (
  input logic             sys_clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             stop_fire,
  input logic             restart,
  input logic             stopped,
  input logic             busy,
  input logic             width_sel,
  input logic             bus_req,
  input logic [CNT_W-1:0] cnt
);

  // R3 R4: the gate only closes in response to a qualifying completion
  assert_close_on_count_R3: assert property (@(negedge sys_clk) disable iff (!rst_n)
    $fell(run_en) |-> $past(stop_fire));

  // R5: while stopped the gate enable is off
  assert_gate_closed_R5: assert property (@(negedge sys_clk) disable iff (!rst_n)
    stopped |-> !run_en);

  // R6: the gate only reopens after a restart request
  assert_open_on_restart_R6: assert property (@(negedge sys_clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(restart));

  // R9: bus request is off when the clock comes back
  assert_busreq_off_R9: assert property (@(negedge sys_clk) disable iff (!rst_n)
    $rose(run_en) |-> !bus_req);

  // R10: width choice frozen while a sequence is active
  assert_width_frozen_R10: assert property (@(negedge sys_clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(width_sel));

  // R4: count never reaches the largest target
  assert_count_bound_R4: assert property (@(negedge sys_clk) disable iff (!rst_n)
    int'(cnt) < LIMIT);

endmodule

bind cstop_ctrl cstop_ctrl_chk #(
  .CNT_W(CNT_W),
  .LIMIT(MAX_N)
) u_chk (
  .sys_clk  (sys_clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .stop_fire(stop_fire),
  .restart  (restart),
  .stopped  (stopped),
  .busy     (busy),
  .width_sel(width_sel),
  .bus_req  (bus_req),
  .cnt      (cnt)
);

// File: tb/cstop_ctrl_test.sv
`timescale 1ns/1ps
module cstop_ctrl_test;

  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;
  localparam logic [23:0] PD = 24'hA5_3C10;

  logic        sys_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_rw = 1'b1;
  logic [2:0]  bus_fc = 3'b110;
  logic        bus_as_n = 1'b1;
  logic        narrow_bus = 1'b0;
  logic        restart = 1'b0;
  logic        hold_req = 1'b0;
  logic [2:0]  ipl_n = 3'b111;
  logic [2:0]  wake_level = 3'd4;
  logic        cpu_clk, bus_req, stopped, wake_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit after_stop = 0;
  bit seen_rise = 0;
  time t_rise = 0;
  int unsigned seed = 32'h1234_5678;

  cstop_ctrl uut (
    .sys_clk(sys_clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_fc(bus_fc), .bus_as_n(bus_as_n), .pd_addr(PD), .narrow_bus(narrow_bus),
    .restart(restart), .hold_req(hold_req), .ipl_n(ipl_n), .wake_level(wake_level),
    .cpu_clk(cpu_clk), .bus_req(bus_req), .stopped(stopped), .wake_hit(wake_hit)
  );

  always #(HALF) sys_clk = ~sys_clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_target(logic narrow);
    return narrow ? 3 : 2;
  endfunction

  function automatic int exp_wake(logic stp, logic [2:0] lines_n, logic [2:0] lvl);
    int level;
    level = 7 - int'(lines_n);
    return (stp && level >= int'(lvl)) ? 1 : 0;
  endfunction

  // R8: pulse shape monitor
  always @(posedge cpu_clk) begin
    chk("R8 rise aligned", int'(sys_clk), 1);
    t_rise = $time;
    seen_rise = 1;
    if (after_stop) begin
      chk("R9 bus_req low at first pulse", int'(bus_req), 0);
      after_stop = 0;
    end
  end
  always @(negedge cpu_clk) begin
    if (seen_rise) chk("R8 pulse width", int'($time - t_rise), HALF);
  end

  // One bus cycle: strobe low over two falling edges, completion at the third.
  task automatic bus_cycle(logic [23:0] a, logic rw, logic [2:0] fc);
    @(posedge sys_clk); #1;
    bus_addr = a; bus_rw = rw; bus_fc = fc; bus_as_n = 1'b0;
    @(posedge sys_clk); #1;
    @(posedge sys_clk); #1;
    bus_as_n = 1'b1;
    @(negedge sys_clk); #1;
    bus_addr = $urandom(); bus_rw = 1'b1; bus_fc = 3'b110;
  endtask

  task automatic match_cycle();
    bus_cycle(PD, 1'b0, 3'b101);
  endtask

  task automatic other_cycle();
    logic [23:0] a;
    a = $urandom();
    if (a == PD) a = a ^ 24'h1;
    bus_cycle(a, 1'($urandom()), 3'($urandom()));
  endtask

  task automatic count_pulses(int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge sys_clk); #1;
      if (cpu_clk) pulses++;
    end
  endtask

  task automatic do_restart(string req);
    @(posedge sys_clk); #1;
    restart = 1'b1;
    after_stop = 1;
    @(negedge sys_clk); #1;
    restart = 1'b0;
    chk({req, " stopped clears"}, int'(stopped), 0);
    chk("R9 bus_req cleared at restart", int'(bus_req), 0);
    @(posedge sys_clk); #1;
    chk({req, " first pulse"}, int'(cpu_clk), 1);
  endtask

  task automatic full_sequence(logic narrow, logic do_hold);
    int tgt;
    int p;
    string rq;
    narrow_bus = narrow;
    hold_req = do_hold;
    tgt = exp_target(narrow);
    rq = narrow ? "R4" : "R3";
    match_cycle();
    chk("R2 after arming cycle", int'(stopped), tgt == 1 ? 1 : 0);
    for (int k = 2; k <= tgt; k++) begin
      other_cycle();
      chk(rq, int'(stopped), k == tgt ? 1 : 0);
    end
    chk("R9 bus_req while stopped", int'(bus_req), int'(do_hold));
    count_pulses(4, p);
    chk("R5 no pulses while stopped", p, 0);
    for (int w = 0; w < 3; w++) begin
      ipl_n = 3'($urandom());
      wake_level = 3'($urandom());
      #1;
      chk("R11 wake random", int'(wake_hit), exp_wake(1'b1, ipl_n, wake_level));
    end
    hold_req = 1'b0;
    do_restart("R6");
  endtask

  initial begin
    int p;
    void'($urandom(seed));
    #(PERIOD * 2 + 2);
    // reset state (clock low at this point: t=22)
    chk("R7 reset stopped", int'(stopped), 0);
    chk("R7 reset bus_req", int'(bus_req), 0);
    chk("R7 reset wake", int'(wake_hit), 0);
    @(negedge sys_clk); #1;
    rst_n = 1'b1;
    @(posedge sys_clk); #1;
    chk("R7 clock runs after reset", int'(cpu_clk), 1);

    // R1: near misses, one term wrong each
    bus_cycle(PD, 1'b1, 3'b101);
    bus_cycle(PD ^ 24'h80_0000, 1'b0, 3'b101);
    bus_cycle(PD ^ 24'h00_0001, 1'b0, 3'b101);
    bus_cycle(PD, 1'b0, 3'b001);
    bus_cycle(PD, 1'b0, 3'b100);
    for (int i = 0; i < 4; i++) other_cycle();
    chk("R1 near misses ignored", int'(stopped), 0);

    // R1: random non-matching traffic
    for (int i = 0; i < 30; i++) begin
      other_cycle();
      chk("R1 random traffic", int'(stopped), 0);
    end
    count_pulses(3, p);
    chk("R1 clock still runs", p, 3);

    // R11: not stopped -> no wake
    ipl_n = 3'b000; wake_level = 3'd0; #1;
    chk("R11 idle no wake", int'(wake_hit), 0);

    // R3 directed, with bus request held
    full_sequence(1'b0, 1'b1);
    // R4 directed
    full_sequence(1'b1, 1'b0);

    // R11 boundaries
    narrow_bus = 1'b0;
    match_cycle(); other_cycle();
    chk("R3 stop for wake test", int'(stopped), 1);
    wake_level = 3'd5;
    ipl_n = ~3'd4; #1; chk("R11 below level", int'(wake_hit), 0);
    ipl_n = ~3'd5; #1; chk("R11 at level", int'(wake_hit), 1);
    ipl_n = ~3'd7; #1; chk("R11 above level", int'(wake_hit), 1);
    do_restart("R6");
    #1; chk("R11 cleared after restart", int'(wake_hit), 0);

    // R6: restart while counting has no effect
    narrow_bus = 1'b0;
    match_cycle();
    @(posedge sys_clk); #1; restart = 1'b1;
    @(negedge sys_clk); #1; restart = 1'b0;
    other_cycle();
    chk("R6 early restart ignored", int'(stopped), 1);
    do_restart("R6");

    // R10: width change mid-sequence ignored
    narrow_bus = 1'b0;
    match_cycle();
    narrow_bus = 1'b1;
    other_cycle();
    chk("R10 width frozen 16-bit", int'(stopped), 1);
    do_restart("R6");
    narrow_bus = 1'b1;
    @(posedge sys_clk); #1;
    match_cycle();
    narrow_bus = 1'b0;
    other_cycle();
    chk("R10 width frozen 8-bit, 2nd", int'(stopped), 0);
    other_cycle();
    chk("R10 width frozen 8-bit, 3rd", int'(stopped), 1);
    do_restart("R6");

    // R7: reset mid-count abandons it
    narrow_bus = 1'b0;
    @(posedge sys_clk); #1;
    match_cycle();
    rst_n = 1'b0;
    @(negedge sys_clk); #1;
    rst_n = 1'b1;
    other_cycle();
    chk("R7 count abandoned", int'(stopped), 0);
    other_cycle();
    chk("R7 still idle", int'(stopped), 0);

    // R7: reset during stop reopens the clock
    match_cycle(); other_cycle();
    chk("R5 stopped before reset", int'(stopped), 1);
    rst_n = 1'b0;
    #1;
    chk("R7 reset ends stop", int'(stopped), 0);
    @(negedge sys_clk); #1;
    rst_n = 1'b1;
    @(posedge sys_clk); #1;
    chk("R7 clock back after reset", int'(cpu_clk), 1);

    // random sequences
    for (int s = 0; s < 6; s++) begin
      for (int j = 0; j < int'($urandom_range(3, 0)); j++) other_cycle();
      full_sequence(1'($urandom()), 1'($urandom()));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0 (timeout)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule